// File: doc/BRIEF.md
# Prescaled Seconds Timer

This block is a free-running up-counter meant for an always-on domain. A slow clock drives a programmable prescaler, and the prescaler advances the counter once per period. With the prescaler set to the slow-clock frequency (32768 for a watch crystal), the counter counts seconds. Each increment is compared against a programmable alarm value. The block raises two sticky status events, one for an alarm match and one for an increment. A level interrupt is produced from the events that have been enabled.

Software reaches the block through a small 32-bit register port clocked by the bus clock. Software cannot load the count. It can only restart the count from zero through a self-clearing bit in the mode register. The count is carried into the bus domain by a two-flop synchroniser followed by a hold register. A read that lands on a changing count can still return an inconsistent value, so software reads the count twice and takes a third read when the two disagree. The status register clears when it is read.

Register map (word address on `busAddr`): 0 mode, 1 alarm value, 2 count (read-only), 3 status (read-only, clear-on-read).

Top module: `seconds_timer`

## Requirements
- R1: After reset, the registers read as follows: mode 0x00008000 (prescaler 32768, all enables off), alarm 0xFFFFFFFF, count 0, status 0. `irqOut` is low.
- R2: Writes to the count address (2) and to the status address (3) have no effect on what those addresses read back.
- R3: Writing mode bit 18 as 1 clears the count and the prescaler phase. The clear takes effect on the third slow-clock edge after the write. Bit 18 always reads back as 0, and the rest of the mode word written with it is kept.
- R4: The prescaler is mode bits 15:0. With a value of P, where P is not 0, the count rises by one every P slow-clock edges after a restart. A value of 0 divides by 65536.
- R5: Status bit 1 (increment) sets whenever the count increments.
- R6: Status bit 0 (alarm) sets on the increment that makes the count equal to the alarm value. Later increments do not set it again.
- R7: An alarm value of all ones disarms the comparator, and no alarm status is raised.
- R8: A read of address 3 returns the status and clears it. An event that arrives in the same bus cycle as that read is kept and reported by the next read.
- R9: Mode bit 16 enables the alarm status and bit 17 enables the increment status, each 16 positions above its status bit. `irqOut` is high while any enabled status bit is set. It stays high until the status is read or the enable is removed.
- R10: A count or status change made on a slow-clock edge becomes visible on the third bus-clock edge after that edge. The count read through the port updates only when two successive synchroniser samples agree.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| busClk | input | 1 | Register-port clock |
| slowClk | input | 1 | Always-on slow clock feeding the prescaler |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| busWrEn | input | 1 | Write strobe, sampled on the busClk rising edge |
| busRdEn | input | 1 | Read strobe; a read of address 3 clears the status |
| busAddr | input | 2 | Word address of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| irqOut | output | 1 | Level interrupt from the enabled status bits |

## Verification
Read data is combinational, so the bench samples it one nanosecond after it sets the address at a falling bus edge. A status clear caused by that read lands on the following rising edge. The slow clock is produced by the bench one pulse at a time, placed between bus edges and stopped between stimuli. A restart needs three slow pulses to take effect. Each count or status change needs three bus edges to appear, so every result check waits four bus cycles.

The crossing latency itself is checked at its exact edges: two reads of the old count followed by one of the new. The same timing is used to land a status read on the very bus edge where an event arrives. The interrupt is sampled two nanoseconds after a rising edge, because it follows the status flops directly.

// File: rtl/seconds_timer_pkg.sv
package seconds_timer_pkg;

  localparam int DATA_W = 32;

  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_ALARM  = 2'd1;
  localparam logic [1:0] ADDR_COUNT  = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;

  // Status bit positions; the event toggles use the same order.
  localparam int ST_ALARM = 0;
  localparam int ST_INC   = 1;

  // Strobes from the register side into the slow-clock datapath.
  typedef struct packed {
    logic restartTgl;
  } ctrlStrobe_t;

  // Event toggles from the datapath back to the register side.
  typedef struct packed {
    logic incTgl;
    logic almTgl;
  } evtToggle_t;

endpackage

// File: rtl/seconds_timer_sync.sv
module seconds_timer_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[0] <= '0;
          else       stage[0] <= dIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[i] <= '0;
          else       stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign qOut = stage[STAGES-1];

endmodule

// File: rtl/seconds_timer_core.sv
module seconds_timer_core
  import seconds_timer_pkg::*;
#(
  parameter int COUNT_W     = 32,
  parameter int PRE_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               slowClk,
  input  logic               rstN,
  input  ctrlStrobe_t        ctrlIn,
  input  logic [PRE_W-1:0]   prescaleIn,
  input  logic [COUNT_W-1:0] alarmIn,
  output logic [COUNT_W-1:0] countOut,
  output evtToggle_t         evtOut
);

  localparam int DIV_W = PRE_W + 1;
  localparam logic [DIV_W-1:0] FULL_DIV = {1'b1, {PRE_W{1'b0}}};

  logic restartSync;
  logic restartPrev;
  logic restartPulse;

  seconds_timer_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_restart_sync (
    .clk  (slowClk),
    .rstN (rstN),
    .dIn  (ctrlIn.restartTgl),
    .qOut (restartSync)
  );

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) restartPrev <= 1'b0;
    else       restartPrev <= restartSync;
  end

  assign restartPulse = restartSync ^ restartPrev;

  // Prescaler: a field of zero selects the full 2^PRE_W division.
  logic [PRE_W-1:0] preCnt;
  logic [DIV_W-1:0] divisor;
  logic [DIV_W-1:0] lastPhase;
  logic             tick;

  assign divisor   = (prescaleIn == '0) ? FULL_DIV : {1'b0, prescaleIn};
  assign lastPhase = divisor - 1'b1;
  // ">=" keeps the phase bounded if the prescaler is lowered mid-period.
  assign tick      = ({1'b0, preCnt} >= lastPhase);

  logic [COUNT_W-1:0] countNext;
  logic               alarmArmed;
  logic               hitAlarm;

  assign countNext  = countOut + 1'b1;
  assign alarmArmed = (alarmIn != '1);
  assign hitAlarm   = alarmArmed && (countNext == alarmIn);

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      countOut <= '0;
      evtOut   <= '0;
    end else if (restartPulse) begin
      preCnt   <= '0;
      countOut <= '0;
    end else if (tick) begin
      preCnt        <= '0;
      countOut      <= countNext;
      evtOut.incTgl <= ~evtOut.incTgl;
      if (hitAlarm) evtOut.almTgl <= ~evtOut.almTgl;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // R3: a restart leaves the count at zero
  assert_restart_zero_R3: assert property (@(posedge slowClk) disable iff (!rstN)
    restartPulse |=> (countOut == '0));

  // R4: outside a restart the count holds or steps by exactly one
  assert_count_step_R4: assert property (@(posedge slowClk) disable iff (!rstN)
    !restartPulse |=> (countOut == $past(countOut) || countOut == $past(countOut) + 1'b1));

  // R5: the increment toggle moves exactly when the count moves
  assert_inc_event_R5: assert property (@(posedge slowClk) disable iff (!rstN)
    !restartPulse |=> ((evtOut.incTgl != $past(evtOut.incTgl)) == (countOut != $past(countOut))));

  // R7: an all-ones alarm never produces an alarm event
  assert_disarmed_R7: assert property (@(posedge slowClk) disable iff (!rstN)
    (alarmIn == '1) |=> $stable(evtOut.almTgl));

endmodule

// File: rtl/seconds_timer_regs.sv
module seconds_timer_regs
  import seconds_timer_pkg::*;
#(
  parameter int COUNT_W     = 32,
  parameter int PRE_W       = 16,
  parameter int PRE_RESET   = 32768,
  parameter int SYNC_STAGES = 2
) (
  input  logic               busClk,
  input  logic               rstN,
  input  logic               wrEnIn,
  input  logic               rdEnIn,
  input  logic [1:0]         addrIn,
  input  logic [DATA_W-1:0]  wrDataIn,
  output logic [DATA_W-1:0]  rdDataOut,
  output logic               irqOut,
  output ctrlStrobe_t        ctrlOut,
  output logic [PRE_W-1:0]   prescaleOut,
  output logic [COUNT_W-1:0] alarmOut,
  input  logic [COUNT_W-1:0] countIn,
  input  evtToggle_t         evtIn
);

  localparam int ALM_EN_BIT  = PRE_W;
  localparam int INC_EN_BIT  = PRE_W + 1;
  localparam int RESTART_BIT = PRE_W + 2;

  logic modeWr;
  logic alarmWr;
  logic statusRd;

  assign modeWr   = wrEnIn && (addrIn == ADDR_MODE);
  assign alarmWr  = wrEnIn && (addrIn == ADDR_ALARM);
  assign statusRd = rdEnIn && (addrIn == ADDR_STATUS);

  logic unusedWrBits;
  assign unusedWrBits = ^wrDataIn[DATA_W-1:RESTART_BIT+1];

  // Configuration registers
  logic [1:0] enReg;   // bit 0 alarm enable, bit 1 increment enable

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      prescaleOut        <= PRE_W'(PRE_RESET);
      enReg              <= '0;
      ctrlOut.restartTgl <= 1'b0;
      alarmOut           <= '1;
    end else begin
      if (modeWr) begin
        prescaleOut <= wrDataIn[PRE_W-1:0];
        enReg       <= {wrDataIn[INC_EN_BIT], wrDataIn[ALM_EN_BIT]};
        if (wrDataIn[RESTART_BIT]) ctrlOut.restartTgl <= ~ctrlOut.restartTgl;
      end
      if (alarmWr) alarmOut <= wrDataIn[COUNT_W-1:0];
    end
  end

  // Event crossing: synchronise the toggles, then detect edges
  logic [1:0] evtSync;
  logic [1:0] evtPrev;
  logic [1:0] evtPulse;

  seconds_timer_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_evt_sync (
    .clk  (busClk),
    .rstN (rstN),
    .dIn  (evtIn),
    .qOut (evtSync)
  );

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) evtPrev <= '0;
    else       evtPrev <= evtSync;
  end

  assign evtPulse = evtSync ^ evtPrev;

  // Clear-on-read status; an event in the read cycle survives
  logic [1:0] statusReg;

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN)         statusReg <= '0;
    else if (statusRd) statusReg <= evtPulse;
    else               statusReg <= statusReg | evtPulse;
  end

  assign irqOut = |(statusReg & enReg);

  // Count crossing: two flops, then a hold register that loads on agreement
  logic [COUNT_W-1:0] countS1;
  logic [COUNT_W-1:0] countS2;
  logic [COUNT_W-1:0] countHold;

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      countS1   <= '0;
      countS2   <= '0;
      countHold <= '0;
    end else begin
      countS1 <= countIn;
      countS2 <= countS1;
      if (countS1 == countS2) countHold <= countS2;
    end
  end

  // Read mux
  always_comb begin
    rdDataOut = '0;
    case (addrIn)
      ADDR_MODE: begin
        rdDataOut[PRE_W-1:0]  = prescaleOut;
        rdDataOut[ALM_EN_BIT] = enReg[ST_ALARM];
        rdDataOut[INC_EN_BIT] = enReg[ST_INC];
      end
      ADDR_ALARM:  rdDataOut[COUNT_W-1:0] = alarmOut;
      ADDR_COUNT:  rdDataOut[COUNT_W-1:0] = countHold;
      ADDR_STATUS: rdDataOut[1:0]         = statusReg;
      default:     rdDataOut = '0;
    endcase
  end

  // R8: an alarm event is recorded even when it meets a status read
  assert_event_kept_R8: assert property (@(posedge busClk) disable iff (!rstN)
    evtPulse[ST_ALARM] |=> statusReg[ST_ALARM]);

  // R8: a status read with no new event leaves the status empty
  assert_status_clear_R8: assert property (@(posedge busClk) disable iff (!rstN)
    (statusRd && evtPulse == 2'b00) |=> (statusReg == 2'b00));

  // R9: the interrupt holds until a status read or a mode write
  assert_irq_hold_R9: assert property (@(posedge busClk) disable iff (!rstN)
    (irqOut && !statusRd && !modeWr) |=> irqOut);

  // R10: the visible count does not move while the synchroniser disagrees
  assert_hold_stable_R10: assert property (@(posedge busClk) disable iff (!rstN)
    (countS1 != countS2) |=> $stable(countHold));

endmodule

// File: rtl/seconds_timer.sv
module seconds_timer
  import seconds_timer_pkg::*;
#(
  parameter int COUNT_W     = 32,
  parameter int PRE_W       = 16,
  parameter int PRE_RESET   = 32768,
  parameter int SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              slowClk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut
);

  ctrlStrobe_t        ctrlStrobe;
  evtToggle_t         evtToggle;
  logic [PRE_W-1:0]   prescale;
  logic [COUNT_W-1:0] alarmVal;
  logic [COUNT_W-1:0] countVal;

  seconds_timer_regs #(
    .COUNT_W     (COUNT_W),
    .PRE_W       (PRE_W),
    .PRE_RESET   (PRE_RESET),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_regs (
    .busClk      (busClk),
    .rstN        (rstN),
    .wrEnIn      (busWrEn),
    .rdEnIn      (busRdEn),
    .addrIn      (busAddr),
    .wrDataIn    (busWrData),
    .rdDataOut   (busRdData),
    .irqOut      (irqOut),
    .ctrlOut     (ctrlStrobe),
    .prescaleOut (prescale),
    .alarmOut    (alarmVal),
    .countIn     (countVal),
    .evtIn       (evtToggle)
  );

  seconds_timer_core #(
    .COUNT_W     (COUNT_W),
    .PRE_W       (PRE_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_core (
    .slowClk    (slowClk),
    .rstN       (rstN),
    .ctrlIn     (ctrlStrobe),
    .prescaleIn (prescale),
    .alarmIn    (alarmVal),
    .countOut   (countVal),
    .evtOut     (evtToggle)
  );

endmodule

// File: tb/seconds_timer_tb.sv
module seconds_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  localparam logic [1:0] A_MODE   = 2'd0;
  localparam logic [1:0] A_ALARM  = 2'd1;
  localparam logic [1:0] A_COUNT  = 2'd2;
  localparam logic [1:0] A_STATUS = 2'd3;

  localparam logic [31:0] RESTART = 32'h0004_0000;
  localparam logic [31:0] ALM_EN  = 32'h0001_0000;
  localparam logic [31:0] INC_EN  = 32'h0002_0000;

  typedef struct packed {
    logic [15:0] pre;
    logic [7:0]  pulses;
    logic [31:0] expCount;
  } vec_t;

  // R4: prescaler, slow pulses after restart, expected count
  localparam vec_t VECS [7] = '{
    '{16'd1, 8'd5,  32'd5},
    '{16'd2, 8'd7,  32'd3},
    '{16'd3, 8'd9,  32'd3},
    '{16'd4, 8'd3,  32'd0},
    '{16'd0, 8'd20, 32'd0},
    '{16'd5, 8'd17, 32'd3},
    '{16'd1, 8'd9,  32'd9}
  };

  logic        busClk = 1'b0;
  logic        slowClk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut;

  int totalCount = 0;
  int failCount  = 0;

  always #(CLK_PERIOD/2) busClk = ~busClk;

  seconds_timer u_dut (
    .busClk    (busClk),
    .slowClk   (slowClk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .irqOut    (irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    totalCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge busClk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge busClk);
    #1 busWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    @(negedge busClk);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRdData;
    @(posedge busClk);
    #1 busRdEn = 1'b0;
  endtask

  task automatic slowPulse();
    @(posedge busClk);
    #3 slowClk = 1'b1;
    #4 slowClk = 1'b0;
  endtask

  task automatic slowRun(input int n);
    for (int k = 0; k < n; k++) slowPulse();
  endtask

  task automatic settle();
    repeat (4) @(posedge busClk);
    #2;
  endtask

  task automatic restartWith(input logic [31:0] modeVal);
    writeReg(A_MODE, modeVal | RESTART);
    slowRun(3);
    settle();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", totalCount - failCount, totalCount);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge busClk);
    failCount++;
    totalCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] rdB;
    logic [31:0] rdC;

    repeat (3) @(posedge busClk);
    @(negedge busClk) rstN = 1'b1;

    // R1: reset values
    readReg(A_MODE, rd);   check("R1 mode reset", rd, 32'h0000_8000);
    readReg(A_ALARM, rd);  check("R1 alarm reset", rd, 32'hFFFF_FFFF);
    readReg(A_COUNT, rd);  check("R1 count reset", rd, 32'd0);
    readReg(A_STATUS, rd); check("R1 status reset", rd, 32'd0);
    check("R1 irq reset", {31'd0, irqOut}, 32'd0);

    // R4: table of prescaler settings
    for (int i = 0; i < 7; i++) begin
      restartWith({16'd0, VECS[i].pre});
      slowRun(int'(VECS[i].pulses));
      settle();
      readReg(A_COUNT, rd);
      check($sformatf("R4 vector %0d count", i), rd, VECS[i].expCount);
    end

    // R2: count and status writes are ignored
    writeReg(A_COUNT, 32'h0000_1234);
    readReg(A_COUNT, rd); check("R2 count write ignored", rd, 32'd9);
    readReg(A_STATUS, rd);
    writeReg(A_STATUS, 32'hFFFF_FFFF);
    readReg(A_STATUS, rd); check("R2 status write ignored", rd, 32'd0);

    // R3: restart clears count, bit reads as zero
    writeReg(A_MODE, RESTART | 32'd1);
    readReg(A_MODE, rd); check("R3 restart bit reads 0", rd, 32'd1);
    slowRun(3);
    settle();
    readReg(A_COUNT, rd); check("R3 count cleared", rd, 32'd0);

    // R10: visible on the third bus edge after the slow edge
    slowPulse();
    readReg(A_COUNT, rd);  check("R10 count after 1 edge", rd, 32'd0);
    readReg(A_COUNT, rdB); check("R10 count after 2 edges", rdB, 32'd0);
    readReg(A_COUNT, rdC); check("R10 count after 3 edges", rdC, 32'd1);

    // R8/R5: event lands in the same cycle as a status read
    settle();
    readReg(A_STATUS, rd);
    slowPulse();
    readReg(A_STATUS, rd);
    readReg(A_STATUS, rdB); check("R8 read coinciding with event", rdB, 32'd0);
    readReg(A_STATUS, rdC); check("R5 increment status kept", rdC, 32'd2);
    readReg(A_STATUS, rd);  check("R8 status cleared by read", rd, 32'd0);

    // R6: alarm status on the matching increment only
    restartWith(32'd2);
    writeReg(A_ALARM, 32'd3);
    readReg(A_STATUS, rd);
    slowRun(4); settle();
    readReg(A_STATUS, rd); check("R6 no alarm before match", rd, 32'd2);
    slowRun(2); settle();
    readReg(A_STATUS, rd); check("R6 alarm at match", rd, 32'd3);
    slowRun(2); settle();
    readReg(A_STATUS, rd); check("R6 no alarm after match", rd, 32'd2);

    // R9: interrupt masking and level behaviour
    writeReg(A_MODE, ALM_EN | 32'd2);
    writeReg(A_ALARM, 32'd6);
    slowRun(4); settle();
    check("R9 irq on enabled alarm", {31'd0, irqOut}, 32'd1);
    repeat (3) @(posedge busClk);
    #2 check("R9 irq held until read", {31'd0, irqOut}, 32'd1);
    readReg(A_STATUS, rd); check("R9 status with alarm", rd, 32'd3);
    check("R9 irq low after read", {31'd0, irqOut}, 32'd0);
    slowRun(2); settle();
    check("R9 increment masked", {31'd0, irqOut}, 32'd0);
    writeReg(A_MODE, ALM_EN | INC_EN | 32'd2);
    check("R9 irq on increment enable", {31'd0, irqOut}, 32'd1);
    readReg(A_MODE, rd); check("R9 enable bit positions", rd, 32'h0003_0002);
    readReg(A_STATUS, rd);
    check("R9 irq cleared by read", {31'd0, irqOut}, 32'd0);

    // R7: all-ones alarm disarms the comparator
    writeReg(A_MODE, 32'd2);
    writeReg(A_ALARM, 32'd9);
    writeReg(A_ALARM, 32'hFFFF_FFFF);
    slowRun(4); settle();
    readReg(A_COUNT, rd);  check("R7 count reached old alarm", rd, 32'd9);
    readReg(A_STATUS, rd); check("R7 no alarm when disarmed", rd, 32'd2);

    summary();
    $finish;
  end

endmodule